// File: doc/BRIEF.md
# Three-Depth Power-Down Controller

This block sequences a chip into and out of three nested sleep depths. Software issues an idle command as a one-cycle request strobe carrying a 2-bit depth code. The controller then drops clock enables for up to three clock domains: the processor core, the on-chip peripherals and the clock synthesizer (PLL). At the shallowest depth only the core clock stops. At the middle depth the peripheral clock stops as well. At the deepest depth the controller also asks the PLL to stop.

Once asleep, the controller stays dormant until a wake event arrives. The wake event is an interrupt; reset also restores the run state. From the two shallow depths a wake event restores every clock on the following cycle. From the deepest depth the wake event first withdraws the PLL stop request. The core and peripheral enables return only after the PLL lock indication has been seen high for a programmable number of consecutive cycles. A 2-bit mode output reports the current depth, so that the surrounding logic can tell a completed wake from one still waiting for lock.

Top module: `pwrdn_ctrl`

## Requirements
- R1: While reset is low and on the first cycle after it is released, the core and peripheral enables are 1, the PLL stop request is 0 and the mode output is 0 (run).
- R2: In run, a request with depth code 2'b01 gives, on the next cycle, core enable 0, peripheral enable 1, PLL stop 0 and mode 1.
- R3: In run, a request with depth code 2'b10 gives, on the next cycle, core and peripheral enables 0, PLL stop 0 and mode 2.
- R4: In run, a request with depth code 2'b11 gives, on the next cycle, core and peripheral enables 0, PLL stop 1 and mode 3.
- R5: A request with depth code 2'b00 is ignored: the controller stays in run with every enable set.
- R6: A power-down state holds with no change to any output for as long as no wake event arrives, and a wake event in run has no effect.
- R7: In mode 1 or mode 2, a wake event returns the controller to run with all enables set on the next cycle, even when an idle request arrives in the same cycle.
- R8: In mode 3, a wake event clears the PLL stop request on the next cycle, while the core and peripheral enables stay 0 and the mode output stays 3.
- R9: After a wake event from mode 3, the controller returns to run only on the cycle after the PLL lock input has been sampled high on LOCK_CYCLES consecutive clock edges (default 4). A low sample restarts the count.
- R10: An idle request that arrives in any power-down state, including the wait for PLL lock, is ignored.
- R11: The PLL lock input has no effect outside the wait for PLL lock after a mode-3 wake.
- R12: The gating is nested: a stopped PLL implies stopped peripherals, and stopped peripherals imply a stopped core.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-running controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idle_req | input | 1 | One-cycle idle command strobe |
| idle_lvl | input | 2 | Requested depth: 01 core, 10 core and peripherals, 11 all including PLL |
| wake | input | 1 | Wake event (interrupt) |
| pll_lock | input | 1 | PLL lock indication |
| cpu_clk_en | output | 1 | Core clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| pll_stop_req | output | 1 | Request to stop the PLL |
| pd_mode | output | 2 | Current depth: 0 run, 1 to 3 power-down depth (3 also while waiting for lock) |

## Verification
The properties assume that the request strobe, depth code, wake and lock inputs are synchronous to the controller clock and hold a known value at every rising edge after reset. The lock-gating property also assumes that the lock input carries its real meaning only during the wait after a mode-3 wake. The stimulus changes every input only on falling clock edges. It drives lock high while the controller is in run, in mode 2 and in mode 3 before the wake, to show that lock is ignored there. It also breaks a lock run with a low sample to exercise the restart of the count.

// File: rtl/pwrdn_pkg.sv
`timescale 1ns/1ps
package pwrdn_pkg;

   localparam int NUM_DOMAINS = 3;
   localparam int DOM_CPU     = 0;
   localparam int DOM_PER     = 1;
   localparam int DOM_PLL     = 2;
   localparam int LVL_W       = 2;
   localparam int MODE_W      = 2;

   typedef enum logic [2:0] {
      ST_RUN    = 3'd0,
      ST_NAP    = 3'd1,
      ST_DOZE   = 3'd2,
      ST_SLEEP  = 3'd3,
      ST_RELOCK = 3'd4
   } pd_state_t;

   // number of domains, counted from the core upward, whose clock is held off
   function automatic logic [1:0] gate_depth(pd_state_t s);
      case (s)
         ST_NAP:    gate_depth = 2'd1;
         ST_DOZE:   gate_depth = 2'd2;
         ST_SLEEP:  gate_depth = 2'd3;
         ST_RELOCK: gate_depth = 2'd2;
         default:   gate_depth = 2'd0;
      endcase
   endfunction

   // depth reported outward; the lock wait still counts as the deepest mode
   function automatic logic [MODE_W-1:0] mode_code(pd_state_t s);
      case (s)
         ST_NAP:    mode_code = 2'd1;
         ST_DOZE:   mode_code = 2'd2;
         ST_SLEEP,
         ST_RELOCK: mode_code = 2'd3;
         default:   mode_code = 2'd0;
      endcase
   endfunction

endpackage

// File: rtl/pwrdn_lvl_dec.sv
`timescale 1ns/1ps
module pwrdn_lvl_dec
   import pwrdn_pkg::*;
#(
   parameter int CODE_W = LVL_W
) (
   input  logic              req,
   input  logic [CODE_W-1:0] lvl,
   output logic              take,
   output pd_state_t         tgt
);

   generate
      if (CODE_W != 2) begin : g_bad_width
         $error("pwrdn_lvl_dec: depth code must be 2 bits wide");
      end
   endgenerate

   always_comb begin
      take = 1'b0;
      tgt  = ST_RUN;
      if (req) begin
         case (lvl)
            2'b01: begin take = 1'b1; tgt = ST_NAP;   end
            2'b10: begin take = 1'b1; tgt = ST_DOZE;  end
            2'b11: begin take = 1'b1; tgt = ST_SLEEP; end
            default: begin take = 1'b0; tgt = ST_RUN; end
         endcase
      end
   end

endmodule

// File: rtl/pwrdn_lock_qual.sv
`timescale 1ns/1ps
module pwrdn_lock_qual #(
   parameter int LOCK_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic lock,
   output logic done
);

   localparam int CW = (LOCK_CYCLES > 1) ? $clog2(LOCK_CYCLES) : 1;

   generate
      if (LOCK_CYCLES < 1) begin : g_bad_count
         $error("pwrdn_lock_qual: LOCK_CYCLES must be at least 1");
      end

      if (LOCK_CYCLES == 1) begin : g_direct
         assign done = arm & lock;
      end else begin : g_count
         logic [CW-1:0] run_cnt;
         logic          at_end;

         assign at_end = (run_cnt == CW'(LOCK_CYCLES - 1));
         assign done   = arm & lock & at_end;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               run_cnt <= '0;
            else if (!arm || !lock || at_end)
               run_cnt <= '0;
            else
               run_cnt <= run_cnt + CW'(1);
         end
      end
   endgenerate

endmodule

// File: rtl/pwrdn_dom_map.sv
`timescale 1ns/1ps
module pwrdn_dom_map
   import pwrdn_pkg::*;
#(
   parameter int NDOM = NUM_DOMAINS
) (
   input  pd_state_t          st,
   output logic [NDOM-1:0]    dom_on,
   output logic [MODE_W-1:0]  mode
);

   logic [1:0] depth;

   generate
      if (NDOM < 1 || NDOM > 3) begin : g_bad_ndom
         $error("pwrdn_dom_map: between 1 and 3 domains supported");
      end
   endgenerate

   assign depth = gate_depth(st);
   assign mode  = mode_code(st);

   generate
      for (genvar d = 0; d < NDOM; d++) begin : g_dom
         assign dom_on[d] = (int'(depth) <= d);
      end
   endgenerate

endmodule

// File: rtl/pwrdn_ctrl.sv
`timescale 1ns/1ps
module pwrdn_ctrl
   import pwrdn_pkg::*;
#(
   parameter int LOCK_CYCLES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              idle_req,
   input  logic [LVL_W-1:0]  idle_lvl,
   input  logic              wake,
   input  logic              pll_lock,
   output logic              cpu_clk_en,
   output logic              per_clk_en,
   output logic              pll_stop_req,
   output logic [MODE_W-1:0] pd_mode
);

   pd_state_t            st_q;
   pd_state_t            st_d;
   pd_state_t            req_tgt;
   logic                 req_take;
   logic                 lock_arm;
   logic                 lock_done;
   logic [NUM_DOMAINS-1:0] dom_on;

   pwrdn_lvl_dec #(.CODE_W(LVL_W)) u_dec (
      .req  (idle_req),
      .lvl  (idle_lvl),
      .take (req_take),
      .tgt  (req_tgt)
   );

   assign lock_arm = (st_q == ST_RELOCK);

   pwrdn_lock_qual #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
      .clk   (clk),
      .rst_n (rst_n),
      .arm   (lock_arm),
      .lock  (pll_lock),
      .done  (lock_done)
   );

   always_comb begin
      st_d = st_q;
      case (st_q)
         ST_RUN:           if (req_take)  st_d = req_tgt;
         ST_NAP, ST_DOZE:  if (wake)      st_d = ST_RUN;
         ST_SLEEP:         if (wake)      st_d = ST_RELOCK;
         ST_RELOCK:        if (lock_done) st_d = ST_RUN;
         default:                         st_d = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_RUN;
      else        st_q <= st_d;
   end

   pwrdn_dom_map #(.NDOM(NUM_DOMAINS)) u_map (
      .st     (st_q),
      .dom_on (dom_on),
      .mode   (pd_mode)
   );

   assign cpu_clk_en   = dom_on[DOM_CPU];
   assign per_clk_en   = dom_on[DOM_PER];
   assign pll_stop_req = ~dom_on[DOM_PLL];

endmodule

// File: rtl/pwrdn_ctrl_chk.sv
`timescale 1ns/1ps
module pwrdn_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       idle_req,
   input logic [1:0] idle_lvl,
   input logic       wake,
   input logic       pll_lock,
   input logic       cpu_clk_en,
   input logic       per_clk_en,
   input logic       pll_stop_req,
   input logic [1:0] pd_mode
);

   always @(posedge clk) begin
      if (!rst_n) begin
         assert_reset_run_R1: assert (cpu_clk_en && per_clk_en && !pll_stop_req && pd_mode == 2'd0);
      end
   end

   assert_nap_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (pd_mode == 2'd0 && idle_req && idle_lvl == 2'b01)
      |=> (pd_mode == 2'd1 && !cpu_clk_en && per_clk_en && !pll_stop_req));

   assert_doze_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pd_mode == 2'd0 && idle_req && idle_lvl == 2'b10)
      |=> (pd_mode == 2'd2 && !cpu_clk_en && !per_clk_en && !pll_stop_req));

   assert_sleep_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pd_mode == 2'd0 && idle_req && idle_lvl == 2'b11)
      |=> (pd_mode == 2'd3 && pll_stop_req));

   assert_zero_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pd_mode == 2'd0 && (!idle_req || idle_lvl == 2'b00))
      |=> (pd_mode == 2'd0 && cpu_clk_en && per_clk_en));

   assert_shallow_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((pd_mode == 2'd1 || pd_mode == 2'd2) && wake)
      |=> (pd_mode == 2'd0 && cpu_clk_en && per_clk_en && !pll_stop_req));

   assert_deep_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pd_mode == 2'd3 && pll_stop_req && wake)
      |=> (!pll_stop_req && !cpu_clk_en && !per_clk_en && pd_mode == 2'd3));

   assert_lock_gates_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(cpu_clk_en) && $past(pd_mode) == 2'd3) |-> $past(pll_lock));

   // R6 and R10: with no wake and no lock, any depth holds even under requests
   assert_idle_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (pd_mode != 2'd0 && !wake && !pll_lock) |=> (pd_mode == $past(pd_mode)));

   assert_sleep_ignores_lock_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (pll_stop_req && !wake) |=> pll_stop_req);

   assert_nested_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (pll_stop_req |-> !per_clk_en) and (!per_clk_en |-> !cpu_clk_en));

endmodule

bind pwrdn_ctrl pwrdn_ctrl_chk u_chk (.*);

// File: tb/pwrdn_ctrl_tb.sv
`timescale 1ns/1ps
module pwrdn_ctrl_tb;

   localparam int LOCKN = 4;
   // {core en, peripheral en, PLL stop, mode}
   localparam logic [4:0] E_RUN    = 5'b11_0_00;
   localparam logic [4:0] E_NAP    = 5'b01_0_01;
   localparam logic [4:0] E_DOZE   = 5'b00_0_10;
   localparam logic [4:0] E_SLEEP  = 5'b00_1_11;
   localparam logic [4:0] E_RELOCK = 5'b00_0_11;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       idle_req = 1'b0;
   logic [1:0] idle_lvl = 2'b00;
   logic       wake = 1'b0;
   logic       pll_lock = 1'b0;
   logic       cpu_clk_en, per_clk_en, pll_stop_req;
   logic [1:0] pd_mode;

   int  n_cmp = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;

   always #2.5 clk = ~clk;

   pwrdn_ctrl #(.LOCK_CYCLES(LOCKN)) u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .idle_req     (idle_req),
      .idle_lvl     (idle_lvl),
      .wake         (wake),
      .pll_lock     (pll_lock),
      .cpu_clk_en   (cpu_clk_en),
      .per_clk_en   (per_clk_en),
      .pll_stop_req (pll_stop_req),
      .pd_mode      (pd_mode)
   );

   task automatic step(int n = 1);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic chk(string tag, logic [4:0] exp);
      logic [4:0] got;
      got = {cpu_clk_en, per_clk_en, pll_stop_req, pd_mode};
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s got=%b exp=%b at %0t", tag, got, exp, $time);
      end
   endtask

   task automatic request(logic [1:0] lvl);
      idle_req = 1'b1;
      idle_lvl = lvl;
      step();
      idle_req = 1'b0;
      idle_lvl = 2'b00;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      step(2);
      chk("R1 in reset", E_RUN);
      rst_n = 1'b1;
      step();
      chk("R1 after release", E_RUN);
   endtask

   task automatic t_zero_and_run();
      request(2'b00);
      chk("R5 code 00 ignored", E_RUN);
      step(2);
      chk("R5 still run", E_RUN);
      wake = 1'b1; step(); wake = 1'b0;
      chk("R6 wake in run", E_RUN);
      pll_lock = 1'b1; step(3); pll_lock = 1'b0;
      chk("R11 lock in run", E_RUN);
   endtask

   task automatic t_nap();
      request(2'b01);
      chk("R2 nap entry", E_NAP);
      step(5);
      chk("R6 nap dormant", E_NAP);
      request(2'b11);
      chk("R10 request in nap", E_NAP);
      wake = 1'b1; step(); wake = 1'b0;
      chk("R7 nap wake", E_RUN);
   endtask

   task automatic t_doze();
      request(2'b10);
      chk("R3 doze entry", E_DOZE);
      pll_lock = 1'b1; step(3); pll_lock = 1'b0;
      chk("R11 lock in doze", E_DOZE);
      wake = 1'b1; idle_req = 1'b1; idle_lvl = 2'b11;
      step();
      wake = 1'b0; idle_req = 1'b0; idle_lvl = 2'b00;
      chk("R7 doze wake beats request", E_RUN);
   endtask

   task automatic t_sleep();
      pll_lock = 1'b1;
      request(2'b11);
      chk("R4 sleep entry", E_SLEEP);
      step(3);
      chk("R11 lock in sleep", E_SLEEP);
      pll_lock = 1'b0;
      wake = 1'b1; step(); wake = 1'b0;
      chk("R8 pll released", E_RELOCK);
      request(2'b01);
      chk("R10 request during relock", E_RELOCK);
      pll_lock = 1'b1;
      for (int i = 1; i < LOCKN; i++) begin
         step();
         chk("R9 lock not yet qualified", E_RELOCK);
      end
      step();
      chk("R9 lock qualified", E_RUN);
      pll_lock = 1'b0;
   endtask

   task automatic t_lock_restart();
      request(2'b11);
      chk("R4 sleep again", E_SLEEP);
      wake = 1'b1; step(); wake = 1'b0;
      chk("R8 relock again", E_RELOCK);
      pll_lock = 1'b1; step(LOCKN - 2);
      pll_lock = 1'b0; step();
      chk("R9 dropout holds relock", E_RELOCK);
      pll_lock = 1'b1; step(LOCKN - 1);
      chk("R9 count restarted", E_RELOCK);
      step();
      chk("R9 run after full run", E_RUN);
      pll_lock = 1'b0;
   endtask

   initial begin
      t_reset();
      t_zero_and_run();
      t_nap();
      t_doze();
      t_sleep();
      t_lock_restart();
      // R12 nesting observed on every state above through the packed checks
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog expired got=running exp=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule